// File: doc/BRIEF.md
# Synchronous Legacy-Peripheral Bus Cycle Timer

This block stretches a CPU bus cycle when the address belongs to a slow peripheral that runs off a shared, free-running enable clock. The block is not told which addresses those are. The peripheral claims the cycle itself by raising a valid-peripheral input alongside the CPU's address strobe. From then on the cycle is no longer ended by a data acknowledge. The block waits for the enable clock to fall, raises valid-memory-address and holds it for one full enable period. The transfer completes on the enable falling edge that follows. At that moment the block latches the peripheral's read data and returns a one-clock completion strobe to the CPU bus state machine.

The enable clock is divided down from the CPU clock and never stops. The length of an access therefore depends on where in the enable period the request lands. With the default divide-by-ten enable (six clocks low, four high), the access takes from 10 to 19 CPU clocks. Interrupt-acknowledge cycles that the peripheral side answers with the valid-peripheral input take exactly the same path and timing. For them, the data on the bus is thrown away and an autovector pulse is raised with the completion strobe instead.

Top module: `legacy_bus_timer`

## Requirements
- R1: `e_clk_o` runs continuously with a period of DIV clocks (default 10). Counting from the first clock edge after reset release, it is low for the first DIV-HIGH_CYC clocks (default 6) and high for the next HIGH_CYC clocks (default 4), and it repeats this pattern whatever the bus does.
- R2: An access is accepted only at a clock edge where the block is idle and both `as_i` and `vpa_i` are high. Either input alone starts nothing: `vma_o` and `done_o` stay low.
- R3: `vma_o` rises in the first low cycle of `e_clk_o`. This is the first enable falling edge at or after the edge that accepts the access, where the accepting edge itself counts if the enable falls on it.
- R4: `done_o` rises at the second enable falling edge at or after the accepting edge and is high for exactly one clock. This puts it 10 to 19 clock edges after the accepting edge with default parameters.
- R5: `vma_o` stays high from its rise through the `done_o` cycle and is low in the clock after `done_o`. No new access is accepted until `as_i` has been seen low.
- R6: On an access with `iack_i` low at acceptance, `data_o` shows the value of `pdata_i` sampled at the edge where `done_o` rises. `autovec_o` stays low.
- R7: On an access with `iack_i` high at acceptance, the timing is identical to R3 to R5. `data_o` keeps its previous value, and `autovec_o` is high in the same single clock as `done_o`.
- R8: While `rst_n` is low, `e_clk_o`, `vma_o`, `done_o` and `autovec_o` are 0 and `data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_i | input | 1 | Address strobe from the CPU bus state machine |
| vpa_i | input | 1 | Valid-peripheral claim: the cycle goes to the synchronous peripheral |
| iack_i | input | 1 | Current bus cycle is an interrupt acknowledge |
| pdata_i | input | DW | Read data from the synchronous peripheral |
| e_clk_o | output | 1 | Free-running peripheral enable clock |
| vma_o | output | 1 | Valid-memory-address to the peripheral |
| done_o | output | 1 | One-clock cycle completion strobe to the CPU |
| autovec_o | output | 1 | Interrupt acknowledge completed: use the autovector |
| data_o | output | DW | Read data returned to the CPU |

## Verification
Embedded assertions watch the alignment on every cycle. They check that valid-memory-address only rises on an enable falling edge and that completion always lands on one. They also check that completion is a single-clock pulse followed by release, and that an acknowledge completion leaves the read data untouched. The exact access length as a function of the enable phase cannot be seen by a per-cycle property, and neither can the full 10-to-19 spread, the enable duty pattern or the ignored half-requests. Only the bench's scenarios show these: it lands requests on every enable phase and compares each measured length against a phase-derived expected value.

// File: rtl/legacy_bus_pkg.sv
package legacy_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALIGN = 3'd1,
    ST_HOLD  = 3'd2,
    ST_DONE  = 3'd3,
    ST_REL   = 3'd4
  } lbt_state_t;
endpackage

// File: rtl/lbt_eclk_gen.sv
module lbt_eclk_gen #(
  parameter int DIV      = 10,
  parameter int HIGH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic e_o,
  output logic last_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int LOW_CYC = DIV - HIGH_CYC;
  localparam logic [PW-1:0] LAST_PH = PW'(DIV - 1);
  localparam logic [PW-1:0] HIGH_START = PW'(LOW_CYC);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                ph_q <= '0;
    else if (ph_q == LAST_PH)  ph_q <= '0;
    else                       ph_q <= ph_q + 1'b1;
  end

  assign e_o    = rst_n && (ph_q >= HIGH_START);
  assign last_o = (ph_q == LAST_PH);

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST_PH); // R1
  AST_E_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_o) |-> (ph_q == '0)); // R1
endmodule

// File: rtl/lbt_cycle_seq.sv
module lbt_cycle_seq
  import legacy_bus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_i,
  input  logic          vpa_i,
  input  logic          iack_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          e_i,
  input  logic          e_last_i,
  output logic          vma_o,
  output logic          done_o,
  output logic          autovec_o,
  output logic [DW-1:0] data_o
);
  lbt_state_t st_q;
  logic       iack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      iack_q <= 1'b0;
      data_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (as_i && vpa_i) begin
            iack_q <= iack_i;
            st_q   <= e_last_i ? ST_HOLD : ST_ALIGN;
          end
        end
        ST_ALIGN: if (e_last_i) st_q <= ST_HOLD;
        ST_HOLD: begin
          if (e_last_i) begin
            st_q <= ST_DONE;
            if (!iack_q) data_o <= pdata_i;
          end
        end
        ST_DONE: st_q <= ST_REL;
        ST_REL:  if (!as_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign vma_o     = (st_q == ST_HOLD) || (st_q == ST_DONE);
  assign done_o    = (st_q == ST_DONE);
  assign autovec_o = (st_q == ST_DONE) && iack_q;

  AST_VMA_ON_E_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vma_o) |-> $fell(e_i)); // R3
  AST_DONE_ON_E_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($fell(e_i) && vma_o)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !vma_o)); // R5
  AST_IACK_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    autovec_o |-> $stable(data_o)); // R7
  AST_AUTOVEC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    autovec_o |-> done_o); // R7
endmodule

// File: rtl/legacy_bus_timer.sv
module legacy_bus_timer #(
  parameter int DIV      = 10,
  parameter int HIGH_CYC = 4,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_i,
  input  logic          vpa_i,
  input  logic          iack_i,
  input  logic [DW-1:0] pdata_i,
  output logic          e_clk_o,
  output logic          vma_o,
  output logic          done_o,
  output logic          autovec_o,
  output logic [DW-1:0] data_o
);
  logic e_last;

  lbt_eclk_gen #(.DIV(DIV), .HIGH_CYC(HIGH_CYC)) u_eclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .e_o    (e_clk_o),
    .last_o (e_last)
  );

  lbt_cycle_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_i      (as_i),
    .vpa_i     (vpa_i),
    .iack_i    (iack_i),
    .pdata_i   (pdata_i),
    .e_i       (e_clk_o),
    .e_last_i  (e_last),
    .vma_o     (vma_o),
    .done_o    (done_o),
    .autovec_o (autovec_o),
    .data_o    (data_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (!vma_o && !done_o))); // R8
endmodule

// File: tb/legacy_bus_timer_test.sv
`timescale 1ns/1ps
module legacy_bus_timer_test;
  localparam int DIV = 10;
  localparam int HI  = 4;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_i = 1'b0, vpa_i = 1'b0, iack_i = 1'b0;
  logic [DW-1:0] pdata_i = '0;
  logic e_clk_o, vma_o, done_o, autovec_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  int cyc = 0;
  logic [DW-1:0] last_data = '0;
  bit e_chk_on = 1'b0;

  always #10 clk = ~clk;

  legacy_bus_timer #(.DIV(DIV), .HIGH_CYC(HI), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .vpa_i(vpa_i), .iack_i(iack_i),
    .pdata_i(pdata_i), .e_clk_o(e_clk_o), .vma_o(vma_o), .done_o(done_o),
    .autovec_o(autovec_o), .data_o(data_o)
  );

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  function automatic bit exp_e(int n);
    return (n % DIV) >= (DIV - HI);
  endfunction

  // edges after the accepting edge until done rises
  function automatic int exp_len(int p);
    return DIV + ((DIV - 1 - p + DIV) % DIV);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 enable clock pattern checked on every falling edge once enabled
  always @(negedge clk) begin
    if (rst_n && e_chk_on) chk(e_clk_o == exp_e(ecnt), "R1 e_clk pattern", e_clk_o, exp_e(ecnt));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_access(int target_p, bit iack, logic [DW-1:0] pd, int hold_after);
    int p, k, j, explen;
    bit seen;
    if (target_p >= 0) begin
      while ((ecnt % DIV) != target_p) @(negedge clk);
    end
    p = ecnt % DIV;
    j = (DIV - 1 - p + DIV) % DIV;
    explen = exp_len(p);
    as_i = 1'b1; vpa_i = 1'b1; iack_i = iack; pdata_i = pd;
    k = 0; seen = 1'b0;
    while (!seen && k < 40) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (done_o) seen = 1'b1;
      else chk(vma_o == (k >= j + 1), "R3 vma timing", vma_o, (k >= j + 1));
    end
    chk(seen && (k - 1) == explen, "R4 access length", k - 1, explen);
    chk((k - 1) >= 10 && (k - 1) <= 19, "R4 length window", k - 1, 10);
    chk(vma_o && !e_clk_o, "R5 vma held at done", vma_o, 1);
    if (iack) begin
      chk(data_o == last_data, "R7 iack data kept", data_o, last_data);
      chk(autovec_o == 1'b1, "R7 autovec with done", autovec_o, 1);
    end else begin
      chk(data_o == pd, "R6 read data", data_o, pd);
      chk(autovec_o == 1'b0, "R6 no autovec", autovec_o, 0);
      last_data = pd;
    end
    for (int h = 0; h <= hold_after; h++) begin
      @(negedge clk);
      chk(!done_o && !vma_o && !autovec_o, "R5 release and no restart", {done_o, vma_o}, 0);
    end
    as_i = 1'b0; vpa_i = 1'b0; iack_i = 1'b0;
    pdata_i = DW'($urandom);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!e_clk_o && !vma_o && !done_o && !autovec_o, "R8 reset outputs",
        {e_clk_o, vma_o, done_o, autovec_o}, 0);
    chk(data_o == '0, "R8 reset data", data_o, 0);
    rst_n = 1'b1;
    e_chk_on = 1'b1;

    // R2: half requests ignored
    vpa_i = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      chk(!vma_o && !done_o, "R2 vpa alone ignored", {vma_o, done_o}, 0);
    end
    vpa_i = 1'b0; as_i = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      chk(!vma_o && !done_o, "R2 strobe alone ignored", {vma_o, done_o}, 0);
    end
    as_i = 1'b0;
    @(negedge clk);

    // directed: every enable phase, best and worst included
    for (int p = 0; p < DIV; p++) run_access(p, 1'b0, DW'(8'h11 * (p + 1)), 0);
    for (int p = 0; p < DIV; p++) run_access(p, 1'b1, DW'(8'hA5 ^ p), 0);
    // strobe held after completion must not restart (R5)
    run_access(DIV - 1, 1'b0, DW'(8'h3C), 6);

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int gap;
      gap = $urandom_range(0, 13);
      repeat (gap) @(negedge clk);
      run_access(-1, ($urandom_range(0, 3) == 0), DW'($urandom), $urandom_range(0, 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule